// File: doc/BRIEF.md
# Command Method Decoder and Validator

This block sits behind a command FIFO and turns a stream of method/data pairs into either stored surface state or one-cycle command pulses. Every method address is looked up in a fixed dispatch table. A table hit carries a per-method mask of the data bits that are allowed to be set, and a kind. The kind says whether the data is written into a state register or whether an action such as execute, write-cache flush, performance trigger, no-op or DMA-slot set is issued. State covers two surfaces (tiling mode, sizes and offsets), addresses, pitches, counts, format, swizzle constants and the query address and counter. A separate read port lets the surrounding copy logic read any stored word back by its method address.

The method input uses a valid/ready handshake. A pair is consumed on a clock edge where both `in_valid` and `in_ready` are high. The block drops `in_ready` for the single cycle in which it shows a command pulse, and for the whole time a host interrupt is pending. While ready is low the source must hold its pair stable. Two faults raise the interrupt: an unknown method, and data with a bit outside the method's mask. In both cases the fault code, the method and the data are latched. No state is written and no pulse is issued. The interrupt stays up until the host pulses `irq_clr`.

Top module: `mthd_decoder`

## Requirements
- R1: After reset `in_ready` is 1, `irq` is 0, `cmd_pulse` is 0, and every stored word reads back as 0.
- R2: An accepted storage method whose data sets no bit outside its mask is written. From the next cycle its value reads back on `rd_data` when `rd_mthd` equals that method. `in_ready` stays 1.
- R3: The masks are as follows. Tile mode is 0x00000FFF. X size and x offset are 0x0007FFFF. Y size and y offset are 0x00001FFF. Z size is 0x000007FF and z offset is 0x00000FFF. Address-high words are 0x000000FF. Pitches are 0x0007FFFF. X count is 0x0000FFFF and y count is 0x00001FFF. Format is 0x0333FFFF. Address-low, swizzle and query-counter words take all 32 bits. Data with any bit outside the mask raises code 2 and leaves the stored word unchanged.
- R4: A method that is not 4-byte aligned, or that hits none of these addresses, raises code 1. Valid addresses are 0x0100, 0x0140, 0x0180–0x018C, 0x0200–0x0218 (source tiling: mode, x size, y size, z size, z offset, x offset, y offset), 0x0220–0x0238 (the same for the destination), 0x0300, 0x0304, and 0x030C–0x0340. The last range holds, in this order: source address high/low, destination address high/low, source pitch, destination pitch, x count, y count, format, two swizzle constants, query address high/low and query counter.
- R5: On a fault, `irq` rises in the cycle after acceptance, with `exc_code`, `exc_mthd` and `exc_data` holding the fault. These stay unchanged while `irq` is high. A cycle with `irq_clr` high drops `irq` at the next edge.
- R6: While `irq` is high, `in_ready` is 0 and a presented pair changes no stored word.
- R7: An accepted action method gives a one-cycle one-hot `cmd_pulse` in the cycle after acceptance. The bits are: bit 0 no-op (0x0100), bit 1 performance trigger (0x0140), bit 2 DMA set, bit 3 execute (0x0300), bit 4 flush (0x0304). `in_ready` is 0 during that cycle.
- R8: A DMA-set method at 0x0180 + 4·k stores its data in slot k and reports k on `cmd_slot` with the pulse. The slot reads back at that same method address.
- R9: `rd_data` is 0 for action methods other than DMA set, and for unknown addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Method/data pair offered |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_mthd | input | 16 | Method byte address |
| in_data | input | 32 | Method data |
| rd_mthd | input | 16 | Method address to read back |
| rd_data | output | 32 | Stored word for `rd_mthd`, combinational |
| cmd_pulse | output | 5 | One-hot one-cycle action pulse |
| cmd_slot | output | 2 | DMA slot index with a DMA pulse |
| irq | output | 1 | Host interrupt, fault pending |
| irq_clr | input | 1 | Host clears the pending interrupt |
| exc_code | output | 2 | 1 = unknown method, 2 = reserved bits set |
| exc_mthd | output | 16 | Method of the faulting pair |
| exc_data | output | 32 | Data of the faulting pair |

## Verification
The assertions assume the host raises `irq_clr` only as a response to a pending interrupt, and never in the same cycle as a new acceptance. That case cannot arise, because `in_ready` is low while `irq` is high. They also assume the source respects back-pressure and does not count a pair as taken while ready is low. The bench drives every input on the falling edge. It pulses `irq_clr` only after it has observed `irq`, and its send task keeps the pair steady until a rising edge sees ready high.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int MW     = 16;             // method address width
  localparam int DW     = 32;             // data width
  localparam int WW     = MW - 2;         // word index width
  localparam int NTILE  = 7;              // tiling words per surface
  localparam int NMISC  = 14;             // words in the misc group
  localparam int NSLOT  = 4;              // DMA target slots
  localparam int DEPTH  = 2 * NTILE + NMISC + NSLOT;
  localparam int IDXW   = $clog2(DEPTH);
  localparam int SLOTW  = $clog2(NSLOT);
  localparam int NCMD   = 5;

  // word addresses (byte address >> 2)
  localparam logic [WW-1:0] W_NOP   = WW'(14'h040);
  localparam logic [WW-1:0] W_PERF  = WW'(14'h050);
  localparam logic [WW-1:0] W_DMA   = WW'(14'h060);
  localparam logic [WW-1:0] W_SRC   = WW'(14'h080);
  localparam logic [WW-1:0] W_DST   = WW'(14'h088);
  localparam logic [WW-1:0] W_EXEC  = WW'(14'h0C0);
  localparam logic [WW-1:0] W_FLUSH = WW'(14'h0C1);
  localparam logic [WW-1:0] W_MISC  = WW'(14'h0C3);
  localparam logic [WW-1:0] W_DMA_L  = W_DMA  + WW'(NSLOT - 1);
  localparam logic [WW-1:0] W_SRC_L  = W_SRC  + WW'(NTILE - 1);
  localparam logic [WW-1:0] W_DST_L  = W_DST  + WW'(NTILE - 1);
  localparam logic [WW-1:0] W_MISC_L = W_MISC + WW'(NMISC - 1);

  // storage index bases
  localparam logic [IDXW-1:0] IDX_SRC  = '0;
  localparam logic [IDXW-1:0] IDX_DST  = IDXW'(NTILE);
  localparam logic [IDXW-1:0] IDX_MISC = IDXW'(2 * NTILE);
  localparam logic [IDXW-1:0] IDX_DMA  = IDXW'(2 * NTILE + NMISC);

  // pulse bit positions
  localparam int P_NOP = 0, P_PERF = 1, P_DMA = 2, P_EXEC = 3, P_FLUSH = 4;

  localparam logic [1:0] EXC_ILLEGAL = 2'd1;
  localparam logic [1:0] EXC_BITS    = 2'd2;

  typedef enum logic [2:0] {
    K_STORE, K_NOP, K_PERF, K_DMA, K_EXEC, K_FLUSH
  } kind_t;

  typedef struct packed {
    logic            hit;
    kind_t           kind;
    logic [DW-1:0]   mask;
    logic [IDXW-1:0] idx;
  } entry_t;

  function automatic logic [DW-1:0] tile_mask(input logic [2:0] k);
    case (k)
      3'd0, 3'd4: return 32'h0000_0FFF;   // mode, z offset
      3'd1, 3'd5: return 32'h0007_FFFF;   // x size, x offset
      3'd2, 3'd6: return 32'h0000_1FFF;   // y size, y offset
      3'd3:       return 32'h0000_07FF;   // z size
      default:    return 32'h0;
    endcase
  endfunction

  function automatic logic [DW-1:0] misc_mask(input logic [3:0] k);
    case (k)
      4'd0, 4'd2, 4'd11: return 32'h0000_00FF;  // address high words
      4'd4, 4'd5:        return 32'h0007_FFFF;  // pitches
      4'd6:              return 32'h0000_FFFF;  // x count
      4'd7:              return 32'h0000_1FFF;  // y count
      4'd8:              return 32'h0333_FFFF;  // format
      default:           return 32'hFFFF_FFFF;  // low addresses, swizzle, counter
    endcase
  endfunction
endpackage

// File: rtl/mdec_lookup.sv
module mdec_lookup
  import mdec_pkg::*;
(
  input  logic [MW-1:0] mthd,
  output entry_t        ent
);
  logic [WW-1:0] w;
  assign w = mthd[MW-1:2];

  always_comb begin
    ent = '{hit: 1'b0, kind: K_STORE, mask: '0, idx: '0};
    if (mthd[1:0] == 2'b00) begin
      if (w == W_NOP) begin
        ent.hit = 1'b1; ent.kind = K_NOP; ent.mask = '1;
      end else if (w == W_PERF) begin
        ent.hit = 1'b1; ent.kind = K_PERF; ent.mask = '1;
      end else if (w == W_EXEC) begin
        ent.hit = 1'b1; ent.kind = K_EXEC; ent.mask = '1;
      end else if (w == W_FLUSH) begin
        ent.hit = 1'b1; ent.kind = K_FLUSH; ent.mask = '1;
      end else if (w >= W_DMA && w <= W_DMA_L) begin
        ent.hit = 1'b1; ent.kind = K_DMA; ent.mask = '1;
        ent.idx = IDX_DMA + IDXW'(w - W_DMA);
      end else if (w >= W_SRC && w <= W_SRC_L) begin
        ent.hit  = 1'b1;
        ent.mask = tile_mask(3'(w - W_SRC));
        ent.idx  = IDX_SRC + IDXW'(w - W_SRC);
      end else if (w >= W_DST && w <= W_DST_L) begin
        ent.hit  = 1'b1;
        ent.mask = tile_mask(3'(w - W_DST));
        ent.idx  = IDX_DST + IDXW'(w - W_DST);
      end else if (w >= W_MISC && w <= W_MISC_L) begin
        ent.hit  = 1'b1;
        ent.mask = misc_mask(4'(w - W_MISC));
        ent.idx  = IDX_MISC + IDXW'(w - W_MISC);
      end
    end
  end
endmodule

// File: rtl/mdec_state.sv
module mdec_state
  import mdec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [DW-1:0]   wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                         mem[i] <= '0;
      else if (we && widx == IDXW'(i))    mem[i] <= wdata;
    end
  end

  assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : '0;
endmodule

// File: rtl/mdec_exc.sv
module mdec_exc
  import mdec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [1:0]    code_in,
  input  logic [MW-1:0] mthd_in,
  input  logic [DW-1:0] data_in,
  input  logic          clr,
  output logic          irq,
  output logic [1:0]    code,
  output logic [MW-1:0] mthd,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      code <= '0;
      mthd <= '0;
      data <= '0;
    end else if (set) begin
      irq  <= 1'b1;
      code <= code_in;
      mthd <= mthd_in;
      data <= data_in;
    end else if (clr) begin
      irq  <= 1'b0;
    end
  end
endmodule

// File: rtl/mthd_decoder.sv
module mthd_decoder
  import mdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MW-1:0]    in_mthd,
  input  logic [DW-1:0]    in_data,
  input  logic [MW-1:0]    rd_mthd,
  output logic [DW-1:0]    rd_data,
  output logic [NCMD-1:0]  cmd_pulse,
  output logic [SLOTW-1:0] cmd_slot,
  output logic             irq,
  input  logic             irq_clr,
  output logic [1:0]       exc_code,
  output logic [MW-1:0]    exc_mthd,
  output logic [DW-1:0]    exc_data
);
  entry_t wr_ent, rd_ent;
  logic   accept, bad_bits, fault, good, store_we;
  logic [DW-1:0]   mem_rd;
  logic [NCMD-1:0] pulse_nxt;

  mdec_lookup u_wr_lookup (.mthd(in_mthd), .ent(wr_ent));
  mdec_lookup u_rd_lookup (.mthd(rd_mthd), .ent(rd_ent));

  assign in_ready = !irq && (cmd_pulse == '0);
  assign accept   = in_valid && in_ready;
  assign bad_bits = wr_ent.hit && ((in_data & ~wr_ent.mask) != '0);
  assign fault    = accept && (!wr_ent.hit || bad_bits);
  assign good     = accept && wr_ent.hit && !bad_bits;
  assign store_we = good && (wr_ent.kind == K_STORE || wr_ent.kind == K_DMA);

  mdec_state u_state (
    .clk(clk), .rst_n(rst_n),
    .we(store_we), .widx(wr_ent.idx), .wdata(in_data),
    .ridx(rd_ent.idx), .rdata(mem_rd)
  );

  assign rd_data = (rd_ent.hit && (rd_ent.kind == K_STORE || rd_ent.kind == K_DMA))
                   ? (mem_rd & rd_ent.mask) : '0;

  always_comb begin
    pulse_nxt = '0;
    if (good) begin
      case (wr_ent.kind)
        K_NOP:   pulse_nxt[P_NOP]   = 1'b1;
        K_PERF:  pulse_nxt[P_PERF]  = 1'b1;
        K_DMA:   pulse_nxt[P_DMA]   = 1'b1;
        K_EXEC:  pulse_nxt[P_EXEC]  = 1'b1;
        K_FLUSH: pulse_nxt[P_FLUSH] = 1'b1;
        default: pulse_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_pulse <= '0;
      cmd_slot  <= '0;
    end else begin
      cmd_pulse <= pulse_nxt;
      if (good && wr_ent.kind == K_DMA)
        cmd_slot <= SLOTW'(wr_ent.idx - IDX_DMA);
    end
  end

  mdec_exc u_exc (
    .clk(clk), .rst_n(rst_n),
    .set(fault), .code_in(wr_ent.hit ? EXC_BITS : EXC_ILLEGAL),
    .mthd_in(in_mthd), .data_in(in_data), .clr(irq_clr),
    .irq(irq), .code(exc_code), .mthd(exc_mthd), .data(exc_data)
  );
endmodule

// File: rtl/mthd_decoder_chk.sv
module mthd_decoder_chk
  import mdec_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [NCMD-1:0] cmd_pulse,
  input logic            irq,
  input logic            irq_clr,
  input logic [1:0]      exc_code,
  input logic [MW-1:0]   exc_mthd,
  input logic [DW-1:0]   exc_data
);
  p_pulse_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_pulse));
  p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |=> (cmd_pulse == '0));
  p_pulse_stalls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pulse != '0) |-> !in_ready);
  p_pulse_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> (cmd_pulse == '0));
  p_irq_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !in_ready);
  p_irq_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  p_irq_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_clr) |=> !irq);
  p_exc_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> ($stable(exc_code) && $stable(exc_mthd) && $stable(exc_data)));
  p_exc_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (exc_code == EXC_ILLEGAL || exc_code == EXC_BITS));
  p_irq_needs_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq)) |-> $past(in_valid && in_ready));
endmodule

bind mthd_decoder mthd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .cmd_pulse(cmd_pulse), .irq(irq), .irq_clr(irq_clr),
  .exc_code(exc_code), .exc_mthd(exc_mthd), .exc_data(exc_data)
);

// File: tb/tb_mthd_decoder.sv
module tb_mthd_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_mthd = '0, rd_mthd = '0;
  logic [31:0] in_data = '0, rd_data;
  logic [4:0]  cmd_pulse;
  logic [1:0]  cmd_slot, exc_code;
  logic        irq, irq_clr = 1'b0;
  logic [15:0] exc_mthd;
  logic [31:0] exc_data;
  int nvec = 0, nfail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mthd_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mthd(in_mthd), .in_data(in_data), .rd_mthd(rd_mthd), .rd_data(rd_data),
    .cmd_pulse(cmd_pulse), .cmd_slot(cmd_slot), .irq(irq), .irq_clr(irq_clr),
    .exc_code(exc_code), .exc_mthd(exc_mthd), .exc_data(exc_data)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // offer a pair, wait for acceptance, return on the falling edge after it
  task automatic send(logic [15:0] m, logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_mthd = m; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [15:0] m, logic [31:0] exp);
    rd_mthd = m; #1;
    chk(req, rd_data, exp);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R5 irq cleared", 32'(irq), 0);
    chk("R5 ready back", 32'(in_ready), 1);
  endtask

  task automatic t_reset();
    chk("R1 ready", 32'(in_ready), 1);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 pulse", 32'(cmd_pulse), 0);
    rd_chk("R1 src mode", 16'h0200, 0);
    rd_chk("R1 query counter", 16'h0340, 0);
    rd_chk("R1 dma slot", 16'h018C, 0);
  endtask

  task automatic t_store();
    send(16'h0200, 32'h0000_0ABC);
    chk("R2 ready after store", 32'(in_ready), 1);
    chk("R2 no pulse", 32'(cmd_pulse), 0);
    send(16'h0310, 32'hDEAD_BEEF);
    send(16'h032C, 32'h0333_FFFF);
    send(16'h0238, 32'h0000_1FFF);
    send(16'h030C, 32'h0000_00A5);
    rd_chk("R2 src mode", 16'h0200, 32'h0000_0ABC);
    rd_chk("R2 src addr low", 16'h0310, 32'hDEAD_BEEF);
    rd_chk("R2 format", 16'h032C, 32'h0333_FFFF);
    rd_chk("R2 dst y offset", 16'h0238, 32'h0000_1FFF);
    rd_chk("R2 src addr high", 16'h030C, 32'h0000_00A5);
  endtask

  task automatic t_bad_bits(logic [15:0] m, logic [31:0] d, logic [31:0] keep);
    send(m, d);
    chk("R3 irq", 32'(irq), 1);
    chk("R3 code", 32'(exc_code), 2);
    chk("R5 method", 32'(exc_mthd), 32'(m));
    chk("R5 data", exc_data, d);
    rd_chk("R3 unchanged", m, keep);
    clear_irq();
  endtask

  task automatic t_illegal(logic [15:0] m);
    send(m, 32'h1234_5678);
    chk("R4 irq", 32'(irq), 1);
    chk("R4 code", 32'(exc_code), 1);
    chk("R4 method", 32'(exc_mthd), 32'(m));
    clear_irq();
  endtask

  task automatic t_pending();
    send(16'h0344, 32'h0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_mthd = 16'h0200; in_data = 32'h0000_0111;
      chk("R6 ready low", 32'(in_ready), 0);
      chk("R5 irq held", 32'(irq), 1);
    end
    @(negedge clk); in_valid = 1'b0;
    rd_chk("R6 no write", 16'h0200, 32'h0000_0ABC);
    chk("R5 data held", 32'(exc_mthd), 32'h0344);
    clear_irq();
  endtask

  task automatic t_action(logic [15:0] m, int bitpos);
    send(m, 32'h0);
    chk("R7 pulse", 32'(cmd_pulse), 32'(1) << bitpos);
    chk("R7 ready low", 32'(in_ready), 0);
    @(negedge clk);
    chk("R7 pulse ends", 32'(cmd_pulse), 0);
    chk("R7 ready back", 32'(in_ready), 1);
  endtask

  task automatic t_dma(int k, logic [31:0] d);
    send(16'h0180 + 16'(4 * k), d);
    chk("R8 pulse", 32'(cmd_pulse), 32'h4);
    chk("R8 slot", 32'(cmd_slot), 32'(k));
    rd_chk("R8 readback", 16'h0180 + 16'(4 * k), d);
  endtask

  task automatic t_read_zero();
    rd_chk("R9 exec", 16'h0300, 0);
    rd_chk("R9 perf", 16'h0140, 0);
    rd_chk("R9 nop", 16'h0100, 0);
    rd_chk("R9 unknown", 16'h0344, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_bad_bits(16'h0200, 32'h0000_1000, 32'h0000_0ABC);
    t_bad_bits(16'h030C, 32'h0000_0100, 32'h0000_00A5);
    t_bad_bits(16'h032C, 32'h0400_0000, 32'h0333_FFFF);
    t_illegal(16'h021C);
    t_illegal(16'h0302);
    t_illegal(16'h0308);
    t_illegal(16'h0344);
    t_pending();
    t_action(16'h0100, 0);
    t_action(16'h0140, 1);
    t_action(16'h0300, 3);
    t_action(16'h0304, 4);
    t_dma(2, 32'h0000_0077);
    t_dma(3, 32'hCAFE_0001);
    t_read_zero();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule